// File: doc/BRIEF.md
# Station Address Match Filter

This block keeps a small table of station MAC addresses and decides, for each received destination address, whether it belongs to one of them. Software fills the table through a plain write port. Each table slot has two 32-bit registers: a low word and a high word. The low word is written first and is only held in a staging register. The later high-word write copies the staged low word and the high word into the active compare value in a single step. That write also sets or clears the slot's valid flag.

The receive path presents a 48-bit destination address with a strobe. Every valid slot is compared in parallel. One clock later the block returns a single-cycle result that gives a hit flag and the index of the matching slot. When more than one slot matches, the lowest index is reported. A synchronous reset empties the whole table. Slot 0 is normally programmed with the device's own address.

Top module: `station_addr_filter`

## Requirements
- R1: After a synchronous reset, `res_valid` and `res_hit` are 0, and a lookup of any address, including all zeros, misses.
- R2: Address byte k is `lk_addr[8k+7:8k]`, and byte 0 is the first octet on the wire. A slot's low word carries byte 0 in bits 7:0, byte 1 in bits 15:8, byte 2 in bits 23:16 and byte 3 in bits 31:24.
- R3: A slot's high word carries byte 4 in bits 7:0 and byte 5 in bits 15:8. Bit 31 requests that the slot be enabled. Bits 30:16 have no effect.
- R4: A high-word write whose 48-bit address is all zeros leaves the slot invalid, even when bit 31 is 1. An all-zero lookup then misses.
- R5: A low-word write by itself does not change the slot's active compare value or its valid flag.
- R6: A high-word write commits the low word staged for that same slot at that moment. Low-word writes to other slots do not disturb this staging. After reset the staged value is zero.
- R7: A high-word write with bit 31 equal to 0 makes the slot invalid, so it no longer matches.
- R8: A strobe at one clock edge gives `res_valid`=1 for exactly the following cycle. Without a strobe, `res_valid` and `res_hit` are 0. Strobes on consecutive cycles give results on consecutive cycles.
- R9: When several valid slots hold the looked-up address, `res_idx` is the lowest such index.
- R10: Synchronous reset clears slots that were programmed earlier, so their addresses miss afterwards.
- R11: On a miss, `res_idx` is 0.
- R12: Write address `wr_sel` = {slot index, word}, where bit 0 = 0 selects the low word and 1 selects the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W (5) | {slot index, word select} |
| wr_data | input | 32 | Write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, byte k in bits 8k+7:8k |
| res_valid | output | 1 | Result strobe, one cycle after `lk_valid` |
| res_hit | output | 1 | Some valid slot matched |
| res_idx | output | IDX_W (4) | Lowest matching slot index, 0 on a miss |

## Verification
Lookups are run against a table that holds distinct addresses in slots 3, 5 and 15. A duplicate in slot 7 checks that the lowest index wins. Slot 9 holds a zero entry written with the enable bit set, which separates a real miss from an all-zero false match.

Near-miss patterns test the byte order and the register split: a byte-reversed address, a single flipped bit, and junk in the ignored high-word bits. Directed sequences then cover the following:
- a low-word write alone
- a low-word write to another slot between staging and commit
- disabling a slot through bit 31
- idle cycles and back-to-back strobes
- a reset after programming, followed by a commit with nothing staged

// File: rtl/saf_pkg.sv
package saf_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned MAC_W  = 48;
    localparam int unsigned HI_W   = MAC_W - WORD_W;
    localparam int unsigned EN_BIT = 31;

    typedef struct packed {
        logic [WORD_W-1:0] stage;
        logic [MAC_W-1:0]  addr;
        logic              vld;
    } slot_state_t;

    localparam slot_state_t SLOT_CLEAR = '{stage: '0, addr: '0, vld: 1'b0};

endpackage

// File: rtl/saf_slot.sv
module saf_slot
    import saf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_low,
    input  logic              wr_high,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [MAC_W-1:0]  lk_addr,
    output logic              match
);

    slot_state_t st_d, st_q;
    logic [MAC_W-1:0] commit_addr;
    logic             unused_hi_bits;

    assign commit_addr    = {wr_data[HI_W-1:0], st_q.stage};
    assign unused_hi_bits = ^wr_data[EN_BIT-1:HI_W];

    always_comb begin
        st_d = st_q;
        if (wr_low) begin
            st_d.stage = wr_data;
        end
        if (wr_high) begin
            st_d.addr = commit_addr;
            st_d.vld  = wr_data[EN_BIT] && (commit_addr != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SLOT_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign match = st_q.vld && (st_q.addr == lk_addr);

    // R5: a lone low-word write leaves the compare value untouched
    p_low_keeps_active_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_low && !wr_high) |=> ($stable(st_q.addr) && $stable(st_q.vld)));

    // R4: a valid slot never holds the zero address
    p_zero_never_valid_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |-> (st_q.addr != '0));

    // R6: the committed low half equals the previously staged word
    p_commit_uses_stage_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_high && !wr_low) |=> (st_q.addr[WORD_W-1:0] == $past(st_q.stage)));

endmodule

// File: rtl/saf_prio.sv
module saf_prio #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

    // R9: the reported slot requests and nothing below it does
    p_lowest_wins_r9: assert property (@(posedge clk) disable iff (rst)
        any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

    // R11: no request gives index zero
    p_idle_idx_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !any |-> (idx == '0));

endmodule

// File: rtl/station_addr_filter.sv
module station_addr_filter
    import saf_pkg::*;
#(
    parameter int unsigned N_SLOTS = 16,
    localparam int unsigned IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int unsigned SEL_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              lk_valid,
    input  logic [MAC_W-1:0]  lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx
);

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } result_t;

    result_t res_d, res_q;

    logic [IDX_W-1:0]   sel_slot;
    logic               sel_high;
    logic [N_SLOTS-1:0] slot_match;
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;

    assign sel_slot = wr_sel[SEL_W-1:1];
    assign sel_high = wr_sel[0];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic wr_this;
        assign wr_this = wr_en && (sel_slot == IDX_W'(g));
        saf_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_low  (wr_this && !sel_high),
            .wr_high (wr_this && sel_high),
            .wr_data (wr_data),
            .lk_addr (lk_addr),
            .match   (slot_match[g])
        );
    end

    saf_prio #(.N(N_SLOTS), .IDX_W(IDX_W)) u_prio (
        .clk (clk),
        .rst (rst),
        .req (slot_match),
        .any (any_hit),
        .idx (hit_idx)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = lk_valid;
        if (lk_valid && any_hit) begin
            res_d.hit = 1'b1;
            res_d.idx = hit_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.vld;
    assign res_hit   = res_q.hit;
    assign res_idx   = res_q.idx;

    // R8: each strobe yields a result in the next cycle
    p_strobe_gives_result_r8: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R8: no strobe, no result
    p_no_strobe_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!res_valid && !res_hit));

    // R11: a miss carries index zero
    p_miss_idx_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_idx == '0));

    // R8: a hit only appears with a result strobe
    p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

endmodule

// File: tb/station_addr_filter_bench.sv
module station_addr_filter_bench;

    localparam int N     = 16;
    localparam int IDX_W = 4;
    localparam int SEL_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [SEL_W-1:0] wr_sel = '0;
    logic [31:0]      wr_data = '0;
    logic             lk_valid = 1'b0;
    logic [47:0]      lk_addr = '0;
    logic             res_valid;
    logic             res_hit;
    logic [IDX_W-1:0] res_idx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    station_addr_filter #(.N_SLOTS(N)) u_station_addr_filter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );

    // lookup vectors: {address, expect hit, expect index}
    localparam int NV = 7;
    localparam logic [52:0] VEC [NV] = '{
        {48'h6655_4433_2211, 1'b1, 4'd3},   // R2 R3 R9: slots 3 and 7 both hold it
        {48'h0A0B_0C0D_0E0F, 1'b1, 4'd5},   // R2
        {48'hFEDC_BA98_7654, 1'b1, 4'd15},  // R3 top slot
        {48'h0000_0000_0000, 1'b0, 4'd0},   // R4 R11
        {48'h1122_3344_5566, 1'b0, 4'd0},   // R2 byte reversal misses
        {48'h0A0B_0C0D_0E0E, 1'b0, 4'd0},   // R11 single-bit difference
        {48'h007F_4433_2211, 1'b0, 4'd0}    // R3 junk bits not part of address
    };

    task automatic wr(input int slot, input bit hi, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = {slot[IDX_W-1:0], hi}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_res(input string tag, input bit v, input bit h, input logic [IDX_W-1:0] i);
        checks++;
        if (res_valid !== v || res_hit !== h || (h && res_idx !== i) || (!h && res_idx !== '0)) begin
            errors++;
            $display("FAIL %s: got valid=%0b hit=%0b idx=%0d, expected valid=%0b hit=%0b idx=%0d",
                     tag, res_valid, res_hit, res_idx, v, h, h ? i : 4'd0);
        end
    endtask

    task automatic look(input string tag, input logic [47:0] a, input bit h, input logic [IDX_W-1:0] i);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        expect_res(tag, 1'b1, h, i);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_res("R1 idle after reset", 1'b0, 1'b0, 4'd0);
        look("R1 zero lookup after reset", 48'h0, 1'b0, 4'd0);

        wr(3, 1'b0, 32'h4433_2211);  wr(3, 1'b1, 32'hFFFF_6655);
        wr(7, 1'b0, 32'h4433_2211);  wr(7, 1'b1, 32'h8000_6655);
        wr(5, 1'b0, 32'h0C0D_0E0F);  wr(5, 1'b1, 32'h8000_0A0B);
        wr(9, 1'b0, 32'h0);          wr(9, 1'b1, 32'h8000_0000);
        wr(15, 1'b0, 32'hBA98_7654); wr(15, 1'b1, 32'h8000_FEDC);

        for (int k = 0; k < NV; k++) begin
            look($sformatf("R2/R3/R4/R9 vector %0d", k), VEC[k][52:5], VEC[k][4], VEC[k][3:0]);
        end

        // R5: low write alone keeps old compare value
        wr(5, 1'b0, 32'h1111_1111);
        look("R5 old address still hits", 48'h0A0B_0C0D_0E0F, 1'b1, 4'd5);
        look("R5 staged address not active", 48'h0A0B_1111_1111, 1'b0, 4'd0);

        // R6: other slot staging does not disturb, commit uses staged word
        wr(6, 1'b0, 32'h2222_2222);
        wr(5, 1'b1, 32'h8000_0A0B);
        look("R6 committed address hits", 48'h0A0B_1111_1111, 1'b1, 4'd5);
        look("R6 previous address gone", 48'h0A0B_0C0D_0E0F, 1'b0, 4'd0);

        // R7: clear enable on slot 3, duplicate in 7 now reported
        wr(3, 1'b1, 32'h0000_6655);
        look("R7 disabled slot skipped", 48'h6655_4433_2211, 1'b1, 4'd7);

        // R8: back-to-back strobes then idle
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 48'hFEDC_BA98_7654;
        @(negedge clk);
        lk_addr = 48'h1234_0000_0000;
        expect_res("R8 first of pair", 1'b1, 1'b1, 4'd15);
        @(negedge clk);
        lk_valid = 1'b0;
        expect_res("R8 second of pair", 1'b1, 1'b0, 4'd0);
        @(negedge clk);
        expect_res("R8 idle quiet", 1'b0, 1'b0, 4'd0);

        // R10: reset clears programmed slots; R6 stage cleared too
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        look("R10 slot 15 cleared", 48'hFEDC_BA98_7654, 1'b0, 4'd0);
        look("R10 slot 7 cleared", 48'h6655_4433_2211, 1'b0, 4'd0);
        wr(2, 1'b1, 32'h8000_1234);
        look("R6 stage zero after reset", 48'h1234_0000_0000, 1'b1, 4'd2);
        // R12: word select bit 0, slot index above
        wr(1, 1'b0, 32'hAAAA_5555); wr(1, 1'b1, 32'h8000_00CC);
        look("R12 select layout", 48'h00CC_AAAA_5555, 1'b1, 4'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule